// File: doc/BRIEF.md
# Two-Byte Parallel Converter Handshake Sequencer

This block runs a successive-approximation analog-to-digital converter that hands back its result over a byte-wide parallel bus. While the run enable is high, the block holds the chip-select and read strobes low. It starts a conversion by pulling the convert line low, and it keeps that line low until the converter's BUSY output is seen high. It then waits for BUSY to go low again, which marks the end of the conversion. Next it reads the result in two bus reads, the upper byte first and then the lower byte. A byte-select line chooses which byte is on the bus.

After each read it delivers the joined word with a one-cycle valid strobe, and it goes straight into the next conversion. BUSY passes through a synchronizer before any decision is made on it. The end of a conversion can be detected in one of two ways, chosen by a mode pin: by the plain level, or by a registered falling-edge detector that takes one more cycle. If BUSY never answers a convert request, a timeout ends the attempt, sends the block back to idle and raises a sticky error.

Top module: `adc_hs_ctrl`

## Requirements
- R1: While reset is applied, and while idle with the run enable low, chip-select, read and convert are all high (inactive), byte-select is low, and the valid and error outputs are low.
- R2: Throughout a conversion, from the convert request to the low-byte read, chip-select and read are held low.
- R3: The convert line goes low to begin a conversion and returns high only after the synchronized BUSY has been observed high.
- R4: If BUSY is not seen high within TIMEOUT_CYC cycles, the convert line is low for exactly TIMEOUT_CYC cycles. The block then returns to idle with chip-select and read high, and it raises the error output. The error holds, and no new conversion starts, while the run enable stays high. Dropping the run enable clears the error.
- R5: In level mode (mode pin 0), byte-select rises exactly SETTLE_CYC+3 clock cycles after BUSY falls at the pin.
- R6: In edge mode (mode pin 1), byte-select rises exactly SETTLE_CYC+4 clock cycles after BUSY falls at the pin, one cycle later than level mode.
- R7: The bus byte read with byte-select low is the most significant byte, and the byte read with byte-select high is the least significant. The output word is {upper byte, lower byte}, with the upper byte in bits 15:8.
- R8: Byte-select stays high for exactly SETTLE_CYC cycles per conversion, and then returns low.
- R9: Each result is presented with a valid pulse exactly one cycle long.
- R10: When the run enable was high at the low-byte read, the convert line is already low again in the cycle in which valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Keep converting while high |
| edge_mode | input | 1 | 0: level end detection, 1: registered falling-edge detection |
| adc_busy | input | 1 | Converter BUSY output (asynchronous) |
| adc_data | input | BYTE_W | Converter parallel data bus |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read enable |
| adc_cnv_n | output | 1 | Active-low convert start |
| adc_byte_sel | output | 1 | 0 selects the upper byte, 1 the lower byte |
| res_word | output | 2*BYTE_W | Last assembled result |
| res_valid | output | 1 | One-cycle strobe for a new result |
| err_timeout | output | 1 | Sticky BUSY timeout error |

## Verification
The bench builds the block with SETTLE_CYC=3 and TIMEOUT_CYC=20. With a timeout that short, a dead converter triggers the timeout path after only twenty cycles, so the exact width of the convert pulse can be counted. A settle count of three leaves room for the bench's converter model, which drives the complement of the correct byte during BUSY and in the first cycle after a byte-select change. An early bus sample therefore turns into a word mismatch. The model also varies the BUSY rise delay and the conversion length, down to a BUSY pulse of two cycles. This exercises both detection modes and checks their one-cycle latency difference.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_BUSY  = 3'd2,
    ST_SETHI = 3'd3,
    ST_SETLO = 3'd4
  } hs_state_t;

  // counter width able to hold the larger of two cycle limits
  function automatic int ctr_bits(input int a, input int b);
    return (a > b) ? $clog2(a + 1) : $clog2(b + 1);
  endfunction

  // cycles from BUSY falling at the pin to byte-select rising
  function automatic int end_to_lo_cycles(input int settle, input int sync_stages,
                                          input bit edge_det);
    return settle + sync_stages + 1 + (edge_det ? 1 : 0);
  endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_lvl,
  output logic busy_fall
);
  logic [STAGES-1:0] chain;
  logic              busy_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= busy_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
    end
  end

  assign busy_lvl = chain[STAGES-1];

  // registered falling edge: one extra cycle over the level view
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev <= 1'b0;
      busy_fall <= 1'b0;
    end else begin
      busy_prev <= busy_lvl;
      busy_fall <= busy_prev & ~busy_lvl;
    end
  end
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] last,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == last);
endmodule

// File: rtl/adc_word_packer.sv
module adc_word_packer #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_cap,
  input  logic                lo_cap,
  input  logic [BYTE_W-1:0]   din,
  output logic [2*BYTE_W-1:0] word,
  output logic                valid
);
  logic [BYTE_W-1:0] hi_q;

  function automatic logic [2*BYTE_W-1:0] join_bytes(input logic [BYTE_W-1:0] upper,
                                                     input logic [BYTE_W-1:0] lower);
    return {upper, lower};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= lo_cap;
      if (hi_cap) hi_q <= din;
      if (lo_cap) word <= join_bytes(hi_q, din);
    end
  end
endmodule

// File: rtl/adc_hs_ctrl.sv
module adc_hs_ctrl
  import adc_hs_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SETTLE_CYC  = 3,
  parameter int TIMEOUT_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                edge_mode,
  input  logic                adc_busy,
  input  logic [BYTE_W-1:0]   adc_data,
  output logic                adc_cs_n,
  output logic                adc_rd_n,
  output logic                adc_cnv_n,
  output logic                adc_byte_sel,
  output logic [2*BYTE_W-1:0] res_word,
  output logic                res_valid,
  output logic                err_timeout
);
  localparam int            CW      = ctr_bits(SETTLE_CYC, TIMEOUT_CYC);
  localparam logic [CW-1:0] TMO_END = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] SET_END = CW'(SETTLE_CYC - 1);

  hs_state_t     state, state_nxt;
  logic          busy_lvl, busy_fall, conv_end;
  logic          phase_done, phase_clr;
  logic [CW-1:0] phase_last;
  logic          tmo_hit, hi_cap, lo_cap;
  logic          err_q;

  adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .busy_async(adc_busy),
    .busy_lvl(busy_lvl), .busy_fall(busy_fall)
  );

  assign phase_last = (state == ST_CONV) ? TMO_END : SET_END;
  assign phase_clr  = (state_nxt != state);

  adc_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(phase_clr), .last(phase_last), .done(phase_done)
  );

  // named events
  assign conv_end = edge_mode ? busy_fall : ~busy_lvl;
  assign tmo_hit  = (state == ST_CONV) && phase_done && !busy_lvl;
  assign hi_cap   = (state == ST_SETHI) && phase_done;
  assign lo_cap   = (state == ST_SETLO) && phase_done;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:  if (run_en && !err_q) state_nxt = ST_CONV;
      ST_CONV:  if (busy_lvl)         state_nxt = ST_BUSY;
                else if (phase_done)  state_nxt = ST_IDLE;
      ST_BUSY:  if (conv_end)         state_nxt = ST_SETHI;
      ST_SETHI: if (phase_done)       state_nxt = ST_SETLO;
      ST_SETLO: if (phase_done)       state_nxt = run_en ? ST_CONV : ST_IDLE;
      default:                        state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      state <= state_nxt;
      if (tmo_hit)      err_q <= 1'b1;
      else if (!run_en) err_q <= 1'b0;
    end
  end

  adc_word_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .hi_cap(hi_cap), .lo_cap(lo_cap),
    .din(adc_data), .word(res_word), .valid(res_valid)
  );

  assign adc_cs_n     = (state == ST_IDLE);
  assign adc_rd_n     = (state == ST_IDLE);
  assign adc_cnv_n    = (state != ST_CONV);
  assign adc_byte_sel = (state == ST_SETLO);
  assign err_timeout  = err_q;

  AST_RUN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cnv_n |-> (!adc_cs_n && !adc_rd_n)); // R2
  AST_CNV_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cnv_n) |-> ($past(busy_lvl) || $past(tmo_hit))); // R3
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (adc_cs_n && adc_rd_n && err_timeout)); // R4
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout && run_en) |=> (adc_cnv_n && err_timeout)); // R4
  AST_HI_BSEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cap |-> !adc_byte_sel); // R7
  AST_LO_BSEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cap |-> adc_byte_sel); // R7
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R9
  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(run_en)) |-> !adc_cnv_n); // R10
endmodule

// File: tb/adc_hs_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_hs_ctrl_tb_top;
  localparam int BW = 8;
  localparam int ST = 3;
  localparam int TO = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, run_en, edge_mode, adc_busy;
  logic [BW-1:0] adc_data;
  logic          adc_cs_n, adc_rd_n, adc_cnv_n, adc_byte_sel, res_valid, err_timeout;
  logic [2*BW-1:0] res_word;

  adc_hs_ctrl #(.BYTE_W(BW), .SETTLE_CYC(ST), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .edge_mode(edge_mode),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_cnv_n(adc_cnv_n), .adc_byte_sel(adc_byte_sel), .res_word(res_word),
    .res_valid(res_valid), .err_timeout(err_timeout)
  );

  int n_cmp = 0, n_bad = 0, n_res = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8001;
      3: return 16'h7FFE;
      default: return 16'((i * 40503) ^ 16'h5AA5);
    endcase
  endfunction

  // converter model, driven just after each rising edge
  bit          dead = 1'b0;
  int          rise_dly = 2, conv_len = 6;
  int          mphase = 0, dcnt = 0, busy_hi_n = 0, pat_i = 0;
  logic [15:0] cur = 16'h0;
  logic        bsel_seen = 1'b0;
  longint      fall_cyc = 0;

  initial begin
    adc_busy = 1'b0;
    adc_data = '0;
    forever begin
      @(posedge clk); #1;
      if (!rst_n) begin
        adc_busy = 1'b0; mphase = 0; bsel_seen = 1'b0;
      end else begin
        case (mphase)
          0: if (!adc_cnv_n && !dead) begin
               cur = pattern(pat_i); pat_i++;
               exp_q.push_back(cur);
               dcnt = rise_dly; mphase = 1;
             end
          1: if (dcnt == 0) begin
               adc_busy = 1'b1; busy_hi_n = 0; dcnt = conv_len; mphase = 2;
             end else dcnt--;
          default: begin
               busy_hi_n++;
               if (dcnt == 0) begin
                 adc_busy = 1'b0; fall_cyc = cyc; mphase = 0;
               end else dcnt--;
             end
        endcase
        // wrong byte while converting or right after a byte-select change
        if (adc_busy || (adc_byte_sel != bsel_seen))
          adc_data = adc_byte_sel ? ~cur[7:0] : ~cur[15:8];
        else
          adc_data = adc_byte_sel ? cur[7:0] : cur[15:8];
        bsel_seen = adc_byte_sel;
      end
    end
  end

  // monitor / scoreboard, sampling on the falling edge
  logic        cnv_prev = 1'b1, bsel_prev = 1'b0, valid_prev = 1'b0, run_prev = 1'b0;
  int          bsel_cnt = 0, cnv_low_cnt = 0;
  bit          strobe_gap = 1'b0;
  logic [15:0] e;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        n_res++;
        chk(!valid_prev, "R9 valid longer than one cycle", 32'(valid_prev), 32'h0);
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected result", 32'(res_word), 32'h0);
        else begin
          e = exp_q.pop_front();
          chk(res_word == e, "R7 result word", 32'(res_word), 32'(e));
        end
        if (run_prev) chk(!adc_cnv_n, "R10 next convert not started", 32'(adc_cnv_n), 32'h0);
      end
      if ((!adc_cnv_n || adc_byte_sel || mphase != 0) && (adc_cs_n || adc_rd_n))
        strobe_gap = 1'b1;
      if (!adc_cnv_n) cnv_low_cnt++;
      if (cnv_prev && !adc_cnv_n) cnv_low_cnt = 1;
      if (!cnv_prev && adc_cnv_n) begin
        if (dead) chk(cnv_low_cnt == TO, "R4 convert low width on timeout",
                      32'(cnv_low_cnt), 32'(TO));
        else chk(busy_hi_n >= 2, "R3 convert released before BUSY seen",
                 32'(busy_hi_n), 32'h2);
      end
      if (adc_byte_sel) bsel_cnt++;
      if (!bsel_prev && adc_byte_sel) begin
        if (edge_mode)
          chk(cyc - fall_cyc == ST + 4, "R6 edge-mode end latency",
              32'(cyc - fall_cyc), 32'(ST + 4));
        else
          chk(cyc - fall_cyc == ST + 3, "R5 level-mode end latency",
              32'(cyc - fall_cyc), 32'(ST + 3));
      end
      if (bsel_prev && !adc_byte_sel) begin
        chk(bsel_cnt == ST, "R8 byte-select high width", 32'(bsel_cnt), 32'(ST));
        bsel_cnt = 0;
      end
    end
    cnv_prev = adc_cnv_n; bsel_prev = adc_byte_sel;
    valid_prev = res_valid; run_prev = run_en;
  end

  task automatic idle_pins(input string tag);
    @(negedge clk);
    chk(adc_cs_n && adc_rd_n, {tag, " cs/rd inactive"}, {adc_cs_n, adc_rd_n}, 32'h3);
    chk(adc_cnv_n && !adc_byte_sel, {tag, " convert high, byte-select low"},
        {adc_cnv_n, adc_byte_sel}, 32'h2);
    chk(!res_valid && !err_timeout, {tag, " valid/error low"},
        {res_valid, err_timeout}, 32'h0);
  endtask

  task automatic run_batch(input bit mode, input int rdly, input int clen, input int count);
    int target;
    @(posedge clk); #1;
    edge_mode = mode; rise_dly = rdly; conv_len = clen;
    target = n_res + count;
    run_en = 1'b1;
    while (n_res < target) @(posedge clk);
    #1 run_en = 1'b0;
    while (!adc_cs_n || exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R7 results outstanding", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; edge_mode = 1'b0;
    repeat (4) @(posedge clk);
    idle_pins("R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    idle_pins("R1 idle");

    run_batch(1'b0, 2, 6, 5);
    run_batch(1'b1, 0, 9, 4);
    run_batch(1'b1, 3, 1, 3);
    run_batch(1'b0, 1, 1, 3);
    chk(!strobe_gap, "R2 cs/rd released mid-conversion", 32'(strobe_gap), 32'h0);

    // timeout: converter never answers
    @(posedge clk); #1;
    dead = 1'b1; run_en = 1'b1;
    while (!err_timeout) @(posedge clk);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(err_timeout && adc_cnv_n, "R4 error held, no restart", {err_timeout, adc_cnv_n}, 32'h3);
    chk(adc_cs_n && adc_rd_n, "R4 idle strobes after timeout", {adc_cs_n, adc_rd_n}, 32'h3);
    @(posedge clk); #1 run_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!err_timeout, "R4 error cleared by run disable", 32'(err_timeout), 32'h0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule